// File: doc/BRIEF.md
# Host Bus Register Select Front End

This block sits between an asynchronous, byte-wide CPU bus and the register file of a serial controller. It decodes three chip-select inputs and three register-select lines into a selected/unselected decision and a 3-bit register index. The CPU's active-low read and write strobes are synchronised to the system clock, and each access becomes a single-cycle read or write enable. The write enable comes with the captured write byte.

An active-low address strobe picks the select mode. While it is low, the select inputs reach the decode directly. When it rises, the last sampled select values are frozen until it falls again, so a multiplexed bus can change the address lines during the data phase. On the read side, the block carries the register file's read byte out on a data-out/output-enable pair, which stands in for a three-state bus. It also drives a driver-disable output that an external transceiver can use to turn its direction around.

Top module: `hbus_select`

## Requirements
- R1: The device is selected only when `cs_a_i`=1, `cs_b_i`=1 and `cs_c_i`=0. With any other combination, no read enable, write enable, output enable or driver-disable assertion is produced, and `reg_idx_o` keeps its value.
- R2: While `addr_strobe_ni` is low, the current `addr_i` and chip-select inputs decide the selection and the index.
- R3: While `addr_strobe_ni` is high, the selection and index are those sampled at the last clock edge at which the strobe was low. Later changes on `addr_i` or the chip selects have no effect.
- R4: A selected read (`rd_ni` falling) gives exactly one cycle of `rd_en_o`, however long the strobe is held. It appears after the third rising clock edge that follows `rd_ni` going low. In that same cycle, `reg_idx_o` shows the register index.
- R5: A selected write (`wr_ni` falling) gives exactly one cycle of `wr_en_o`, with the same timing as R4. In that cycle, `reg_idx_o` holds the index and `wr_data_o` holds the `wdata_i` byte that was present on the edge that raised the enable.
- R6: `drv_dis_o` is low only while a selected read is in progress, with the same latency as R4. It returns high three edges after `rd_ni` rises, and it stays high during writes.
- R7: `bus_oe_o` is high exactly when `drv_dis_o` is low. While `bus_oe_o` is high, `bus_data_o` carries `rdata_i` delayed by one register stage; otherwise it is zero.
- R8: After reset, `rd_en_o`=0, `wr_en_o`=0, `bus_oe_o`=0, `drv_dis_o`=1 and `reg_idx_o`=0. The held select is unselected, so an access made with the address strobe held high since reset is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register-select lines |
| cs_a_i | input | 1 | Chip select, active high |
| cs_b_i | input | 1 | Chip select, active high |
| cs_c_i | input | 1 | Chip select, active low |
| addr_strobe_ni | input | 1 | Low: selects pass through; high: selects held |
| rd_ni | input | 1 | CPU read strobe, active low |
| wr_ni | input | 1 | CPU write strobe, active low |
| wdata_i | input | 8 | CPU write data |
| rdata_i | input | 8 | Read byte from the register file at `reg_idx_o` |
| reg_idx_o | output | 3 | Register index of the current access |
| rd_en_o | output | 1 | One-cycle read enable |
| wr_en_o | output | 1 | One-cycle write enable |
| wr_data_o | output | 8 | Captured write byte |
| bus_data_o | output | 8 | Read data toward the CPU bus |
| bus_oe_o | output | 1 | Output enable for `bus_data_o` |
| drv_dis_o | output | 1 | Driver disable, low during a selected read |

## Verification
On every cycle, the assertions check that each enable lasts only one cycle and that the index moves only together with an enable. They also check that a read enable occurs only inside an active read window, that the output enable and driver disable stay complementary, and that the data-out is quiet while it is not enabled. Only the bench scenarios can show whether the chip-select decode is right, whether the address strobe really holds a captured select while the lines change, the exact enable latency, and the value of the captured write byte and read byte.

// File: rtl/hbus_pkg.sv
package hbus_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 8;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              hit;
  } sel_t;
endpackage

// File: rtl/hbus_sel_latch.sv
module hbus_sel_latch
  import hbus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_a_i,
  input  logic              cs_b_i,
  input  logic              cs_c_i,
  output sel_t              sel_o
);
  sel_t live, held_q;

  always_comb begin
    live.addr = addr_i;
    live.hit  = cs_a_i & cs_b_i & ~cs_c_i;
  end

  // track while strobe low; the last tracked value stays once it rises
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) held_q <= '{addr: '0, hit: 1'b0};
    else if (!strobe_ni) held_q <= live;
  end

  assign sel_o = strobe_ni ? held_q : live;
endmodule

// File: rtl/hbus_strobe_sync.sv
module hbus_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic level_o,
  output logic lead_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], ~strobe_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign lead_o  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/hbus_select.sv
module hbus_select
  import hbus_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cs_a_i,
  input  logic              cs_b_i,
  input  logic              cs_c_i,
  input  logic              addr_strobe_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] reg_idx_o,
  output logic              rd_en_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_oe_o,
  output logic              drv_dis_o
);
  localparam int unsigned N_STRB = 2;  // 0: read, 1: write

  sel_t              sel;
  logic [N_STRB-1:0] strb_n, lvl, lead;
  logic              rd_go, wr_go, rd_act;
  logic [ADDR_W-1:0] idx_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              rd_en_q, wr_en_q, oe_q;

  hbus_sel_latch u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .strobe_ni (addr_strobe_ni),
    .addr_i    (addr_i),
    .cs_a_i    (cs_a_i),
    .cs_b_i    (cs_b_i),
    .cs_c_i    (cs_c_i),
    .sel_o     (sel)
  );

  assign strb_n = {wr_ni, rd_ni};

  for (genvar g = 0; g < N_STRB; g++) begin : g_strb
    hbus_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .strobe_ni (strb_n[g]),
      .level_o   (lvl[g]),
      .lead_o    (lead[g])
    );
  end

  assign rd_go  = lead[0] & sel.hit;
  assign wr_go  = lead[1] & sel.hit;
  // a read window needs the write strobe idle
  assign rd_act = lvl[0] & ~lvl[1] & sel.hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      idx_q   <= '0;
      wdat_q  <= '0;
      rdat_q  <= '0;
      oe_q    <= 1'b0;
    end else begin
      rd_en_q <= rd_go;
      wr_en_q <= wr_go;
      if (rd_go || wr_go) idx_q <= sel.addr;
      if (wr_go) wdat_q <= wdata_i;
      oe_q    <= rd_act;
      rdat_q  <= rd_act ? rdata_i : '0;
    end
  end

  assign reg_idx_o  = idx_q;
  assign rd_en_o    = rd_en_q;
  assign wr_en_o    = wr_en_q;
  assign wr_data_o  = wdat_q;
  assign bus_data_o = rdat_q;
  assign bus_oe_o   = oe_q;
  assign drv_dis_o  = ~oe_q;
endmodule

// File: rtl/hbus_select_chk.sv
module hbus_select_chk
  import hbus_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] reg_idx_o,
  input logic              rd_en_o,
  input logic              wr_en_o,
  input logic [DATA_W-1:0] bus_data_o,
  input logic              bus_oe_o,
  input logic              drv_dis_o
);
  a_r4_rd_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |=> !rd_en_o);

  a_r5_wr_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  a_r1_idx_only_on_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_en_o || wr_en_o) |-> $stable(reg_idx_o));

  a_r6_rd_in_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> !drv_dis_o);

  a_r7_oe_vs_dis: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o != drv_dis_o);

  a_r7_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_oe_o |-> bus_data_o == '0);
endmodule

bind hbus_select hbus_select_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_idx_o  (reg_idx_o),
  .rd_en_o    (rd_en_o),
  .wr_en_o    (wr_en_o),
  .bus_data_o (bus_data_o),
  .bus_oe_o   (bus_oe_o),
  .drv_dis_o  (drv_dis_o)
);

// File: tb/hbus_select_tb_top.sv
`timescale 1ns/1ps
module hbus_select_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       cs_a_i = 1'b0, cs_b_i = 1'b0, cs_c_i = 1'b1;
  logic       addr_strobe_ni = 1'b1;
  logic       rd_ni = 1'b1, wr_ni = 1'b1;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_i;
  logic [2:0] reg_idx_o;
  logic       rd_en_o, wr_en_o, bus_oe_o, drv_dis_o;
  logic [7:0] wr_data_o, bus_data_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  // register file model: byte depends on index
  assign rdata_i = 8'h50 + {5'd0, reg_idx_o};

  hbus_select dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_cs(input bit a, input bit b, input bit c);
    cs_a_i = a; cs_b_i = b; cs_c_i = c;
  endtask

  // read access: hold rd low 8 cycles, watch enable position and bus
  task automatic do_read(input bit exp_sel, input logic [2:0] exp_idx, input string tag);
    int pulses = 0, at = 0, oe_seen = 0;
    logic [2:0] idx_before = reg_idx_o;
    @(negedge clk_i) rd_ni = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk_i);
      if (rd_en_o) begin pulses++; at = c; end
      if (bus_oe_o) oe_seen++;
      if (c == 6 && exp_sel)
        chk(bus_data_o == 8'h50 + exp_idx && !drv_dis_o, {tag, " R7 read byte"}, bus_data_o, 8'h50 + exp_idx);
    end
    chk(pulses == (exp_sel ? 1 : 0), {tag, " R4 pulse count"}, pulses, exp_sel ? 1 : 0);
    if (exp_sel) begin
      chk(at == 3, {tag, " R4 pulse cycle"}, at, 3);
      chk(reg_idx_o == exp_idx, {tag, " R4 index"}, reg_idx_o, exp_idx);
      chk(oe_seen == 6, {tag, " R6 window"}, oe_seen, 6);
    end else begin
      chk(oe_seen == 0 && drv_dis_o, {tag, " R1 no drive"}, oe_seen, 0);
      chk(reg_idx_o == idx_before, {tag, " R1 index kept"}, reg_idx_o, idx_before);
    end
    @(negedge clk_i) rd_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(drv_dis_o && !bus_oe_o && bus_data_o == 0, {tag, " R6 release"}, drv_dis_o, 1);
  endtask

  task automatic do_write(input bit exp_sel, input logic [2:0] exp_idx, input logic [7:0] d, input string tag);
    int pulses = 0, at = 0, drv = 0;
    logic [2:0] idx_before = reg_idx_o;
    @(negedge clk_i) begin wr_ni = 1'b0; wdata_i = d; end
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk_i);
      if (wr_en_o) begin
        pulses++; at = c;
        chk(wr_data_o == d && reg_idx_o == exp_idx, {tag, " R5 data/index"}, {reg_idx_o, wr_data_o}, {exp_idx, d});
      end
      if (!drv_dis_o) drv++;
    end
    chk(pulses == (exp_sel ? 1 : 0), {tag, " R5 pulse count"}, pulses, exp_sel ? 1 : 0);
    if (exp_sel) chk(at == 3, {tag, " R5 pulse cycle"}, at, 3);
    else chk(reg_idx_o == idx_before, {tag, " R1 index kept"}, reg_idx_o, idx_before);
    chk(drv == 0, {tag, " R6 no drive on write"}, drv, 0);
    @(negedge clk_i) wr_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic t_reset;
    chk(!rd_en_o && !wr_en_o && !bus_oe_o && drv_dis_o && reg_idx_o == 0, "R8 reset outputs",
        {rd_en_o, wr_en_o, bus_oe_o, drv_dis_o}, 4'b0001);
    // strobe high since reset: held select is unselected even with valid inputs
    set_cs(1, 1, 0); addr_i = 3'd4;
    do_read(0, 3'd0, "R8 held-unselected");
  endtask

  task automatic t_transparent;
    @(negedge clk_i) addr_strobe_ni = 1'b0;
    set_cs(1, 1, 0); addr_i = 3'd5;
    do_read(1, 3'd5, "R2 read");
    addr_i = 3'd2;
    do_write(1, 3'd2, 8'h9C, "R2 write");
    addr_i = 3'd7;
    do_write(1, 3'd7, 8'h36, "R5 write2");
  endtask

  task automatic t_decode;
    addr_i = 3'd1;
    set_cs(0, 1, 0); do_read(0, 3'd0, "R1 cs_a low");
    set_cs(1, 0, 0); do_read(0, 3'd0, "R1 cs_b low");
    set_cs(1, 1, 1); do_write(0, 3'd0, 8'hEE, "R1 cs_c high");
  endtask

  task automatic t_hold;
    @(negedge clk_i) begin addr_strobe_ni = 1'b0; addr_i = 3'd6; set_cs(1, 1, 0); end
    @(negedge clk_i) addr_strobe_ni = 1'b1;
    @(negedge clk_i) begin addr_i = 3'd1; set_cs(0, 0, 1); end
    do_read(1, 3'd6, "R3 held select");
    // capture unselected, then present a valid select while held
    @(negedge clk_i) begin addr_strobe_ni = 1'b0; set_cs(1, 1, 1); addr_i = 3'd0; end
    @(negedge clk_i) addr_strobe_ni = 1'b1;
    @(negedge clk_i) begin addr_i = 3'd3; set_cs(1, 1, 0); end
    do_write(0, 3'd0, 8'h11, "R3 held unselected");
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_transparent();
    t_decode();
    t_hold();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=0 exp=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule